// File: doc/BRIEF.md
# Paged PHY Management Access Engine

This block is a register-programmed management-bus master for Ethernet PHYs. Software fills four 32-bit control words with the target address, page or device, register number and write data. It then sets a go bit. The engine produces the serial clock and data line for two complete management frames and, for reads, captures the 16 returned bits into the shared data word. When the transaction ends, the engine drops the go bit.

Two access flavours are offered. The first is a paged direct access, which selects a page through PHY register 31 and then touches the target register. The second is an extended-device access, which sends an address frame and then a read or write frame. Reads take the PHY address from the upper half of the data word. Writes take it from a one-hot port bitmap, and the upper half of the data word carries the value to be written.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset all four control words read as zero, `mdc` is low and `mdio_oe` is low.
- R2: Writing word 1 with bit 0 set while idle starts a transaction. Bit 0 reads back as 1 until the second frame has ended and then reads 0. Every other bit of word 1 keeps the value written.
- R3: While bit 0 of word 1 is set, register writes to any word are ignored.
- R4: A paged read (word 1 bit 1 = 0, bit 2 = 0) sends two frames to PHY address word2[20:16]. The first is {32 ones, 01, 01, addr, 11111, 10, 0000, page}, with the page taken from word1[14:3]. The second is {32 ones, 01, 10, addr, reg}, with the register taken from word1[24:20]; it then releases the line for turnaround and 16 data bits. The data, MSB first, lands in word2[15:0] and word2[31:16] is unchanged.
- R5: A paged write (bit 2 = 1) uses as PHY address the lowest set bit of word 0. The first frame matches R4 and the second is {32 ones, 01, 01, addr, reg, 10, word2[31:16]}.
- R6: With bit 1 set, the first frame is {32 ones, 00, 00, addr, dev, 10, word3[15:0]}, with the device taken from word3[20:16]. The second frame uses opcode 11 for a read (line released after the device field) or 01 for a write (followed by 10 and word2[31:16]). PHY address selection follows R4 and R5.
- R7: `mdc` has a period of 2×MDC_HALF system clocks, `mdio_o` changes only on a falling edge of `mdc`, and read data is sampled on rising edges.
- R8: Bits 19:15 of word 1 are stored and read back, and they have no effect on any frame.
- R9: `mdio_oe` is high for every bit of a write frame. In read frames it is low from the turnaround onward, and it is low outside frames.
- R10: A write whose port bitmap is all zero addresses PHY 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Control word select (0..3) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected control word |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Serial data from PHY |
| mdio_o | output | 1 | Serial data to PHY |
| mdio_oe | output | 1 | Serial data drive enable |

## Verification
The hardest case to reach from the ports is a register write that arrives mid-transaction. Such a write would corrupt the frame still being shifted, or the data word waiting for read capture. The bench starts a paged read and, while the go bit is still set, writes junk into every word and attempts a second start. It then checks that the frames, the captured data and the bitmap all reflect only the original program. A bench PHY responder decodes each frame bit by bit on the rising clock and drives reply data after falling edges. This lets it check read capture for both access flavours against random reply values.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

    localparam int FRAME_W   = 64;
    localparam int PRE_W     = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int PAGE_W    = 12;
    localparam int RELEASE_AT = PRE_W + 14;   // first turnaround bit index
    localparam int DATA_AT    = RELEASE_AT + 2;

    // control word 1 bit positions
    localparam int GO_BIT   = 0;
    localparam int MMD_BIT  = 1;
    localparam int WR_BIT   = 2;
    localparam int PAGE_LSB = 3;
    localparam int REG_LSB  = 20;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_F1_LOAD,
        SQ_F1_RUN,
        SQ_F2_LOAD,
        SQ_F2_RUN,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic                mmd;
        logic                wr;
        logic [ADDR_W-1:0]   phy;
        logic [ADDR_W-1:0]   regno;
        logic [PAGE_W-1:0]   page;
        logic [ADDR_W-1:0]   devad;
        logic [DATA_W-1:0]   mreg;
        logic [DATA_W-1:0]   wdata;
    } mdio_cmd_t;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [1:0]        st,
        input logic [1:0]        op,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] r5,
        input logic [DATA_W-1:0] data
    );
        return {{PRE_W{1'b1}}, st, op, phy, r5, 2'b10, data};
    endfunction

    function automatic logic [ADDR_W-1:0] lowest_port(input logic [31:0] map);
        logic [ADDR_W-1:0] p;
        p = '0;
        for (int i = 31; i >= 0; i--) begin
            if (map[i]) p = ADDR_W'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int MDC_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick     = (cnt == CW'(MDC_HALF - 1));
    assign rise_stb = tick & ~mdc;
    assign fall_stb = tick & mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_eng_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               is_read,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               active,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);
    logic [FRAME_W-1:0] sh;
    logic               rd;
    logic [6:0]         bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            rd      <= 1'b0;
            bit_cnt <= '0;
            active  <= 1'b0;
            done    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (load && !active) begin
                sh      <= frame;
                rd      <= is_read;
                active  <= 1'b1;
                bit_cnt <= '0;
            end else if (active && fall_stb) begin
                if (bit_cnt == 7'(FRAME_W)) begin
                    active  <= 1'b0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                    done    <= 1'b1;
                end else begin
                    mdio_o  <= sh[FRAME_W-1];
                    sh      <= {sh[FRAME_W-2:0], 1'b0};
                    mdio_oe <= !(rd && (bit_cnt >= 7'(RELEASE_AT)));
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (active && rise_stb && rd && (bit_cnt > 7'(DATA_AT))) begin
                rdata <= {rdata[DATA_W-2:0], mdio_i};
            end
        end
    end

    // R7
    mdio_o_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $past(fall_stb));

    // R2
    load_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !active);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_eng_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  mdio_cmd_t          cmd,
    input  logic               f_done,
    output logic               f_load,
    output logic [FRAME_W-1:0] f_frame,
    output logic               f_read,
    output logic               done
);
    seq_state_e state, nxt;
    logic [FRAME_W-1:0] frame1, frame2;
    logic [1:0] st2, op2;
    logic [ADDR_W-1:0] r5_2;

    always_comb begin
        if (cmd.mmd) begin
            frame1 = build_frame(2'b00, 2'b00, cmd.phy, cmd.devad, cmd.mreg);
            st2    = 2'b00;
            op2    = cmd.wr ? 2'b01 : 2'b11;
            r5_2   = cmd.devad;
        end else begin
            frame1 = build_frame(2'b01, 2'b01, cmd.phy, 5'd31, {4'b0, cmd.page});
            st2    = 2'b01;
            op2    = cmd.wr ? 2'b01 : 2'b10;
            r5_2   = cmd.regno;
        end
        frame2 = build_frame(st2, op2, cmd.phy, r5_2, cmd.wdata);
    end

    always_comb begin
        nxt     = state;
        f_load  = 1'b0;
        f_frame = frame1;
        f_read  = 1'b0;
        done    = 1'b0;
        unique case (state)
            SQ_IDLE:    if (go) nxt = SQ_F1_LOAD;
            SQ_F1_LOAD: begin
                f_load = 1'b1;
                nxt    = SQ_F1_RUN;
            end
            SQ_F1_RUN:  if (f_done) nxt = SQ_F2_LOAD;
            SQ_F2_LOAD: begin
                f_load  = 1'b1;
                f_frame = frame2;
                f_read  = !cmd.wr;
                nxt     = SQ_F2_RUN;
            end
            SQ_F2_RUN:  if (f_done) nxt = SQ_DONE;
            SQ_DONE: begin
                done = 1'b1;
                nxt  = SQ_IDLE;
            end
            default:    nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

    // R2
    frame_done_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        f_done |-> (state == SQ_F1_RUN || state == SQ_F2_RUN));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_eng_pkg::*;
#(
    parameter int MDC_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [31:0] w0, w1, w2, w3;
    logic        busy, go, go_q;
    logic        rise_stb, fall_stb;
    logic        f_load, f_read, f_done, f_active, seq_done;
    logic [FRAME_W-1:0] f_frame;
    logic [DATA_W-1:0]  f_rdata;
    mdio_cmd_t   cmd;

    assign busy = w1[GO_BIT];
    assign go   = reg_wr && !busy && (reg_addr == 2'd1) && reg_wdata[GO_BIT];

    always_comb begin
        cmd.mmd   = w1[MMD_BIT];
        cmd.wr    = w1[WR_BIT];
        cmd.phy   = w1[WR_BIT] ? lowest_port(w0) : w2[20:16];
        cmd.regno = w1[REG_LSB +: ADDR_W];
        cmd.page  = w1[PAGE_LSB +: PAGE_W];
        cmd.devad = w3[20:16];
        cmd.mreg  = w3[15:0];
        cmd.wdata = w2[31:16];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w0 <= '0; w1 <= '0; w2 <= '0; w3 <= '0;
            go_q <= 1'b0;
        end else begin
            go_q <= go;
            if (seq_done) begin
                w1[GO_BIT] <= 1'b0;
                if (!w1[WR_BIT]) w2[15:0] <= f_rdata;
            end else if (reg_wr && !busy) begin
                unique case (reg_addr)
                    2'd0: w0 <= reg_wdata;
                    2'd1: w1 <= reg_wdata;
                    2'd2: w2 <= reg_wdata;
                    2'd3: w3 <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            2'd0: reg_rdata = w0;
            2'd1: reg_rdata = w1;
            2'd2: reg_rdata = w2;
            default: reg_rdata = w3;
        endcase
    end

    mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) u_clk (
        .clk(clk), .rst(rst), .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_seq u_seq (
        .clk(clk), .rst(rst), .go(go_q), .cmd(cmd), .f_done(f_done),
        .f_load(f_load), .f_frame(f_frame), .f_read(f_read), .done(seq_done)
    );

    mdio_shifter u_sh (
        .clk(clk), .rst(rst), .load(f_load), .frame(f_frame), .is_read(f_read),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .active(f_active), .done(f_done),
        .rdata(f_rdata)
    );

    // R3
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        busy && reg_wr && !seq_done |=> $stable(w0) && $stable(w2) && $stable(w3));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !seq_done |=> busy);

    // R2
    done_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> busy);

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && !f_active |-> !mdio_oe);
endmodule

// File: tb/sim_mdio_mgmt_engine.sv
module sim_mdio_mgmt_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_engine #(.MDC_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY responder / frame recorder
    int          bcnt = 0;
    int          nfr  = 0;
    logic [63:0] cur_v, cur_oe;
    logic [63:0] fr_v [4];
    logic [63:0] fr_oe [4];
    logic        rd_frame = 1'b0;
    logic [15:0] resp = '0;

    always @(posedge mdc) begin
        if (bcnt != 0 || mdio_oe) begin
            cur_v  = {cur_v[62:0], mdio_o};
            cur_oe = {cur_oe[62:0], mdio_oe};
            bcnt++;
            if (bcnt == 36)
                rd_frame = (cur_v[3:0] == 4'b0110) || (cur_v[3:0] == 4'b0011);
            if (bcnt == 64) begin
                if (nfr < 4) begin
                    fr_v[nfr]  = cur_v;
                    fr_oe[nfr] = cur_oe;
                end
                nfr++;
                bcnt = 0;
                rd_frame = 1'b0;
            end
        end
    end

    always @(negedge mdc) begin
        #1;
        if (rd_frame && bcnt >= 48 && bcnt < 64) mdio_i = resp[15 - (bcnt - 48)];
        else mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [63:0] xframe(input logic [1:0] st, input logic [1:0] op,
            input logic [4:0] phy, input logic [4:0] r5, input logic [15:0] data);
        return {32'hFFFF_FFFF, st, op, phy, r5, 2'b10, data};
    endfunction

    function automatic logic [4:0] first_bit(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return 5'(i);
        return 5'd0;
    endfunction

    localparam logic [63:0] RD_MASK = 64'hFFFF_FFFF_FFFC_0000;

    task automatic run_txn(input string req, input bit mmd, input bit wr,
            input logic [31:0] map, input logic [15:0] hi, input logic [4:0] regno,
            input logic [11:0] page, input logic [4:0] sticky, input logic [4:0] devad,
            input logic [15:0] mreg, input logic [15:0] rsp, input bit poke);
        logic [31:0] w1v, rv;
        logic [63:0] e1, e2;
        logic [4:0]  phy;
        int          guard;
        wr_reg(2'd0, map);
        wr_reg(2'd2, {hi, 16'h0000});
        wr_reg(2'd3, {11'd0, devad, mreg});
        resp = rsp;
        nfr  = 0;
        w1v = {7'd0, regno, sticky, page, wr, mmd, 1'b1};
        wr_reg(2'd1, w1v);
        if (poke) begin
            repeat (20) @(negedge clk);
            wr_reg(2'd2, 32'hDEAD_BEEF);
            wr_reg(2'd0, 32'h8000_0000);
            wr_reg(2'd3, 32'h001F_FFFF);
            wr_reg(2'd1, 32'h0000_0007);
        end
        guard = 0;
        rv = 32'h1;
        while (rv[0] && guard < 5000) begin
            rd_reg(2'd1, rv);
            guard++;
        end
        phy = wr ? first_bit(map) : hi[4:0];
        if (mmd) begin
            e1 = xframe(2'b00, 2'b00, phy, devad, mreg);
            e2 = xframe(2'b00, wr ? 2'b01 : 2'b11, phy, devad, hi);
        end else begin
            e1 = xframe(2'b01, 2'b01, phy, 5'd31, {4'd0, page});
            e2 = xframe(2'b01, wr ? 2'b01 : 2'b10, phy, regno, hi);
        end
        repeat (4) @(negedge clk);
        chk({req, " frame count"}, 64'(nfr), 64'd2);
        chk({req, " first frame"}, fr_v[0], e1);
        chk("R9 first frame drive", fr_oe[0], {64{1'b1}});
        if (wr) begin
            chk({req, " second frame"}, fr_v[1], e2);
            chk("R9 write frame drive", fr_oe[1], {64{1'b1}});
        end else begin
            chk({req, " second frame"}, fr_v[1] & RD_MASK, e2 & RD_MASK);
            chk("R9 read release", fr_oe[1], RD_MASK);
        end
        chk("R2 go cleared, word1 kept", 64'(rv), 64'(w1v & 32'hFFFF_FFFE));
        rd_reg(2'd2, rv);
        chk({req, " data word"}, 64'(rv), 64'({hi, wr ? 16'h0000 : rsp}));
        if (poke) begin
            rd_reg(2'd0, rv);
            chk("R3 bitmap untouched", 64'(rv), 64'(map));
        end
    endtask

    // watchdog
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        time t0, t1;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), rv);
            chk("R1 word reset", 64'(rv), 64'd0);
        end
        chk("R1 mdio_oe reset", 64'(mdio_oe), 64'd0);

        // R7 clock period
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        chk("R7 mdc period", 64'(t1 - t0), 64'(2 * HALF * CLK_PERIOD));

        run_txn("R4", 0, 0, 32'h0, 16'h0005, 5'd2, 12'h123, 5'd0, 5'd0, 16'h0, 16'hA5C3, 0);
        run_txn("R5", 0, 1, 32'h0000_1200, 16'h3C5A, 5'd17, 12'h0AB, 5'd0, 5'd0, 16'h0, 16'h0, 0);
        run_txn("R10", 0, 1, 32'h0, 16'hFFFF, 5'd0, 12'h000, 5'd0, 5'd0, 16'h0, 16'h0, 0);
        run_txn("R6", 1, 0, 32'h0, 16'h001E, 5'd0, 12'h000, 5'd0, 5'd7, 16'hBEEF, 16'h1357, 0);
        run_txn("R6", 1, 1, 32'h8000_0000, 16'h4321, 5'd0, 12'h000, 5'd0, 5'd31, 16'h0102, 16'h0, 0);
        run_txn("R8", 0, 0, 32'h0, 16'h0019, 5'd31, 12'hFFF, 5'h1F, 5'd0, 16'h0, 16'h8001, 0);
        run_txn("R3", 0, 0, 32'h0000_0040, 16'h0003, 5'd9, 12'h055, 5'd0, 5'd0, 16'h0, 16'h6E6E, 1);
        for (int k = 0; k < 10; k++) begin
            bit m, w;
            logic [31:0] map;
            m = 1'($urandom % 2);
            w = 1'($urandom % 2);
            map = (32'h1 << ($urandom % 32)) | (($urandom % 2) ? 32'h8000_0000 : 32'h0);
            run_txn(m ? "R6" : (w ? "R5" : "R4"), m, w, map, 16'($urandom),
                5'($urandom), 12'($urandom), 5'($urandom), 5'($urandom),
                16'($urandom), 16'($urandom), 0);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule